// File: doc/BRIEF.md
# Sixteen-by-Sixteen Multiplier Built from Nibble Tiles

This block multiplies two 16-bit unsigned operands and returns their full 32-bit product in a single combinational path, with no registers. Each operand is cut into four 4-bit nibbles. A small 4x4 tile multiplies every nibble of `x` by every nibble of `y`, which gives sixteen 8-bit tile products. Inside each tile the product bits come from vertical and crosswise AND columns that are summed from the least significant column upward.

The tile products are sorted into seven classes by nibble weight. The class of a tile is the sum of the two nibble indices, from 0 to 6. A product in class k lands 4·k bits up the result. Its low nibble falls into result nibble k and its high nibble into result nibble k+1. Each result nibble position owns one slice. Every slice gathers its 4-bit terms and sums them with a balanced adder tree. A ripple pass across the slices then moves the excess above each nibble into the next slice. The block is meant to sit on the datapath of an arithmetic unit wherever an unsigned wide product is needed within one cycle.

Top module: `nibble_tile_mul16`

## Requirements
- R1: For every pair of 16-bit unsigned operands, `z` equals the exact product `x*y` as a 32-bit value.
- R2: Each 4x4 tile returns the exact 8-bit product of its two nibbles. That product never exceeds 225, and it is zero whenever either nibble is zero.
- R3: `z[3:0]` equals the low nibble of the product `x[3:0]*y[3:0]`.
- R4: The slice that sits above result nibble 7 never receives a carry, so discarding it loses nothing.
- R5: If either operand is zero, then `z` is zero.
- R6: If one operand is 1, then `z` equals the other operand, zero-extended to 32 bits.
- R7: The all-ones operands give `z = 32'hFFFE0001`.
- R8: An operand of `16'h8000` gives `z` equal to the other operand shifted left by 15 bits.
- R9: Take an `x` with only nibble i nonzero (bits 4i+3..4i) and a `y` with only nibble j nonzero. Then `z` equals the nibble product shifted left by 4·(i+j) bits. This holds for every i, j in 0..3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 16 | Unsigned multiplicand |
| y | input | 16 | Unsigned multiplier |
| z | output | 32 | Unsigned product x*y |

## Verification
The bench walks a single nonzero nibble of `x` against a single nonzero nibble of `y` over all sixteen index pairs, using random nibble values. A router that placed a weight class one slice off, or that swapped the upper and lower halves of a tile product, would then show a product moved by four bits. The operands 0, 1, `16'h8000` and `16'hFFFF` are crossed in every combination. All-ones drives every slice and every inter-slice carry to its maximum, so a carry that is dropped or too narrow shows up as a wrong top nibble. The value 1 exposes a tile that misses a crosswise term. The value `16'h8000` exposes an error in the top weight class. Ten thousand seeded random pairs then compare `z` against a wide reference product computed in the bench.

// File: rtl/tile_mul_pkg.sv
package tile_mul_pkg;
    localparam int NIB_W   = 4;
    localparam int NIB_CNT = 4;
endpackage

// File: rtl/nib_xmul.sv
module nib_xmul
    import tile_mul_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int AW     = $clog2(W * W + 1) + 2;
    localparam int PMAX_I = ((1 << W) - 1) * ((1 << W) - 1);

    logic [2*W-1:0] p_d;

    // Vertical and crosswise columns, summed from the low column upward.
    always_comb begin
        logic [AW-1:0] run;
        run = '0;
        p_d = '0;
        for (int c = 0; c < 2 * W; c++) begin
            for (int i = 0; i < W; i++) begin
                if ((c - i) >= 0 && (c - i) < W) begin
                    run = run + AW'(a[i] & b[c-i]);
                end
            end
            p_d[c] = run[0];
            run    = run >> 1;
        end
    end

    assign p = p_d;

    always_comb begin
        assert_zero_operand_R2: assert ((a != '0 && b != '0) || p == '0)
            else $error("tile product nonzero with zero operand");
        assert_tile_bound_R2: assert (32'(p) <= 32'(PMAX_I))
            else $error("tile product exceeds maximum");
    end
endmodule

// File: rtl/diag_router.sv
module diag_router
    import tile_mul_pkg::*;
#(
    parameter int W = NIB_W,
    parameter int N = NIB_CNT
) (
    input  logic [N*N-1:0][2*W-1:0]           prod,
    output logic [2*N-1:0][2*N-1:0][W-1:0]    terms
);
    // Slot i of result nibble n: low half of tile (i, n-i).
    // Slot N+i of result nibble n: high half of tile (i, n-1-i).
    always_comb begin
        terms = '0;
        for (int n = 0; n < 2 * N; n++) begin
            for (int i = 0; i < N; i++) begin
                if ((n - i) >= 0 && (n - i) < N) begin
                    terms[n][i] = prod[i*N+(n-i)][W-1:0];
                end
                if ((n - 1 - i) >= 0 && (n - 1 - i) < N) begin
                    terms[n][N+i] = prod[i*N+(n-1-i)][2*W-1:W];
                end
            end
        end
    end
endmodule

// File: rtl/col_tree.sv
module col_tree
    import tile_mul_pkg::*;
#(
    parameter int W  = NIB_W,
    parameter int T  = 2 * NIB_CNT,
    parameter int LV = $clog2(T),
    parameter int SW = W + LV
) (
    input  logic [T-1:0][W-1:0] terms,
    output logic [SW-1:0]       sum
);
    localparam int TP = 1 << LV;

    logic [SW-1:0] sum_d;

    always_comb begin
        logic [TP-1:0][SW-1:0] lvl;
        lvl = '0;
        for (int t = 0; t < T; t++) begin
            lvl[t] = SW'(terms[t]);
        end
        for (int l = 0; l < LV; l++) begin
            for (int t = 0; t < TP / 2; t++) begin
                if (t < (TP >> (l + 1))) begin
                    lvl[t] = lvl[2*t] + lvl[2*t+1];
                end
            end
        end
        sum_d = lvl[0];
    end

    assign sum = sum_d;
endmodule

// File: rtl/slice_chain.sv
module slice_chain
    import tile_mul_pkg::*;
#(
    parameter int W  = NIB_W,
    parameter int C  = 2 * NIB_CNT,
    parameter int SW = NIB_W + $clog2(2 * NIB_CNT)
) (
    input  logic [C-1:0][SW-1:0] colsum,
    output logic [C*W-1:0]       z,
    output logic                 spill
);
    logic [C*W-1:0] z_d;
    logic           spill_d;

    always_comb begin
        logic [SW:0] run;
        run = '0;
        z_d = '0;
        for (int n = 0; n < C; n++) begin
            run            = run + (SW+1)'(colsum[n]);
            z_d[n*W +: W]  = run[W-1:0];
            run            = run >> W;
        end
        spill_d = |run;
    end

    assign z     = z_d;
    assign spill = spill_d;
endmodule

// File: rtl/nibble_tile_mul16.sv
module nibble_tile_mul16
    import tile_mul_pkg::*;
#(
    parameter int W = NIB_W,
    parameter int N = NIB_CNT
) (
    input  logic [N*W-1:0]   x,
    input  logic [N*W-1:0]   y,
    output logic [2*N*W-1:0] z
);
    localparam int C  = 2 * N;
    localparam int LV = $clog2(C);
    localparam int SW = W + LV;

    logic [N*N-1:0][2*W-1:0]        prod;
    logic [C-1:0][C-1:0][W-1:0]     terms;
    logic [C-1:0][SW-1:0]           colsum;
    logic [2*N*W-1:0]               z_d;
    logic                           spill;

    for (genvar gi = 0; gi < N; gi++) begin : g_xn
        for (genvar gj = 0; gj < N; gj++) begin : g_yn
            nib_xmul #(.W(W)) i_tile (
                .a (x[gi*W +: W]),
                .b (y[gj*W +: W]),
                .p (prod[gi*N+gj])
            );
        end
    end

    diag_router #(.W(W), .N(N)) i_router (
        .prod  (prod),
        .terms (terms)
    );

    for (genvar gc = 0; gc < C; gc++) begin : g_col
        col_tree #(.W(W), .T(C), .LV(LV), .SW(SW)) i_tree (
            .terms (terms[gc]),
            .sum   (colsum[gc])
        );
    end

    slice_chain #(.W(W), .C(C), .SW(SW)) i_chain (
        .colsum (colsum),
        .z      (z_d),
        .spill  (spill)
    );

    assign z = z_d;

    always_comb begin
        assert_low_nibble_R3: assert (z_d[W-1:0] == prod[0][W-1:0])
            else $error("low result nibble differs from tile 0 low half");
        assert_no_overflow_R4: assert (!spill)
            else $error("carry left the top slice");
        assert_zero_operand_R5: assert ((x != '0 && y != '0) || z_d == '0)
            else $error("zero operand gave nonzero product");
        assert_unit_operand_R6: assert (y != (N*W)'(1) || z_d == (2*N*W)'(x))
            else $error("unit multiplier did not pass x through");
    end
endmodule

// File: tb/test_nibble_tile_mul16.sv
module test_nibble_tile_mul16;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic [15:0] x;
    logic [15:0] y;
    logic [31:0] z;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    nibble_tile_mul16 i_nibble_tile_mul16 (
        .x (x),
        .y (y),
        .z (z)
    );

    function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
        logic [63:0] wide;
        wide = 64'(a) * 64'(b);
        return wide[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s x=%h y=%h actual=%h expected=%h", tag, x, y, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b);
        x = a;
        y = b;
        #(CLK_PERIOD / 2);
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] corners [4];
        int unsigned seed_v;
        corners[0] = 16'h0000;
        corners[1] = 16'h0001;
        corners[2] = 16'hFFFF;
        corners[3] = 16'h8000;
        seed_v = $urandom(32'h5EED_1234);

        // Reset-like starting point: both operands zero.
        apply(16'h0000, 16'h0000);
        check("R5 start", z, 32'h0);

        // Corner cross product.
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                apply(corners[i], corners[j]);
                check("R1 corner", z, ref_mul(corners[i], corners[j]));
            end
        end

        apply(16'hFFFF, 16'hFFFF);
        check("R7 all ones", z, 32'hFFFE0001);

        for (int k = 0; k < 20; k++) begin
            logic [15:0] v;
            v = 16'($urandom);
            apply(v, 16'h0000);
            check("R5 y zero", z, 32'h0);
            apply(16'h0000, v);
            check("R5 x zero", z, 32'h0);
            apply(v, 16'h0001);
            check("R6 y one", z, {16'h0, v});
            apply(16'h0001, v);
            check("R6 x one", z, {16'h0, v});
            apply(v, 16'h8000);
            check("R8 y msb", z, {1'b0, v, 15'h0});
            apply(16'h8000, v);
            check("R8 x msb", z, {1'b0, v, 15'h0});
            apply(v, 16'($urandom));
            check("R3 low nibble", {28'h0, z[3:0]}, {28'h0, 4'(v[3:0] * y[3:0])});
        end

        // Single-nibble routing by weight class.
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                for (int r = 0; r < 4; r++) begin
                    logic [3:0] na;
                    logic [3:0] nb;
                    logic [31:0] expv;
                    na = (r == 0) ? 4'hF : 4'($urandom);
                    nb = (r == 0) ? 4'hF : 4'($urandom);
                    expv = (32'(na) * 32'(nb)) << (4 * (i + j));
                    apply(16'(na) << (4 * i), 16'(nb) << (4 * j));
                    check("R9 nibble pair", z, expv);
                    check("R2 tile value", 32'((z >> (4 * (i + j))) & 32'hFF), 32'(na) * 32'(nb));
                end
            end
        end

        // Random operands; the top slice stays free of carry (R4).
        for (int k = 0; k < 10000; k++) begin
            logic [15:0] a;
            logic [15:0] b;
            a = 16'($urandom);
            b = 16'($urandom);
            apply(a, b);
            check("R1 random R4", z, ref_mul(a, b));
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule